// File: doc/BRIEF.md
# Display Link Power Sequencer

This block controls the power-up and power-down of a display link controller. It covers two power domains. The bus domain is a supply rail plus a bus clock. The link domain is a link clock, the lanes' ultra-low-power (ULP) state and the output clamps. A request carries a direction bit and two domain bits. For each request the block issues a series of step commands to external sub-units. Each command is a one-cycle pulse with a step code. After each pulse the block waits for one acknowledgement that carries an ok/fail bit.

During power-up, any failed step stops the sequence. The block then undoes the rail, bus-clock and link-clock steps it had already completed, last first, and reports the code of the failed step. Power-down always runs to the end. It puts the lanes into ULP and clamps them only when the configuration inputs ask for it. The block tracks whether the lanes are in ULP and whether the clamps are engaged, and it uses both flags to choose the power-up steps.

Top module: `dls_pwr_seq`

## Requirements
- R1: After reset, busy, done and step_pulse are 0, err_code is 0, and the ULP and clamp flags are both 0.
- R2: A step is issued as a single-cycle step_pulse together with step_code. No second step is issued until the current one has been acknowledged or has timed out. Step codes: 1 rail on, 2 bus clock on, 3 link clock on, 4 ULP enter, 5 ULP exit, 6 clamp on, 7 clamp off, 8 link clock off, 9 bus clock off, 10 rail off.
- R3: Power-up of the bus domain issues rail on (1) and then bus clock on (2). If bus clock on fails, rail off (10) follows and err_code is 2.
- R4: Power-up of the link domain issues link clock on (3), followed by ULP exit (5) when the ULP flag is set. If the clamp flag is set when the request arrives, the block first issues ULP enter (4) and then clamp off (7), and only after those the link clock on.
- R5: When a power-up step fails, the block undoes the steps that completed during the same request, in this order: link clock off, then bus clock off, then rail off. It undoes only the completed ones among link clock on, bus clock on and rail on. Failures during undo are ignored. err_code holds the code of the step that failed.
- R6: Power-down of the link domain issues ULP enter, link clock off and then clamp on. It does so only when the ULP feature is enabled and the panel is on, or when ULP-in-suspend is enabled and the panel is off. In every other case it issues link clock off alone.
- R7: Power-down of the bus domain issues bus clock off and then rail off. Step failures during power-down are ignored, and power-down always reports err_code 0.
- R8: When both domain bits are set, power-up handles the bus domain before the link domain, and power-down handles the link domain before the bus domain.
- R9: A step that gets no acknowledgement within TIMEOUT_CYC cycles of waiting counts as a failed step.
- R10: The ULP flag is set by a successful ULP enter and cleared by a successful ULP exit. The clamp flag is set by a successful clamp on and cleared by a successful clamp off. Failed or timed-out steps leave both flags unchanged.
- R11: A request that arrives while busy is ignored. A request with neither domain bit set completes with err_code 0 and issues no step.
- R12: done is a one-cycle pulse that ends every accepted request. busy is 1 from the cycle after acceptance through the done cycle, and is 0 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_enable | input | 1 | 1 = power up, 0 = power down |
| req_bus | input | 1 | Bus domain selected |
| req_link | input | 1 | Link domain selected |
| cfg_lp_feature | input | 1 | ULP feature enabled |
| cfg_panel_on | input | 1 | Panel is powered |
| cfg_lp_suspend | input | 1 | ULP-in-suspend enabled |
| step_pulse | output | 1 | One-cycle step command strobe |
| step_code | output | 4 | Code of the issued step |
| ack_valid | input | 1 | Step acknowledgement |
| ack_ok | input | 1 | 1 = step succeeded |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (one cycle) |
| err_code | output | 4 | Code of the failed step, 0 = success |
| lp_state | output | 1 | Lanes are in ULP |
| clamp_state | output | 1 | Clamps are engaged |

## Verification
The bench goes after the failure paths. A failed bus clock start must release the rail; an adder that skipped this would leave the rail on. A late ULP exit failure must tear down all three completed steps in reverse order; a design that unwound in forward order, or left steps out, would show a wrong step sequence. A silent sub-unit must end the request through the timeout with err_code 3 instead of hanging. The bench also checks that the clamp-release ordering is driven by the clamp flag, that the down-path gate chooses correctly between the full ULP-and-clamp path and the plain clock stop, that a failed rail-off during power-down still reports success, and that a request poked in while busy adds no steps.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [3:0] {
    STP_NONE      = 4'd0,
    STP_REG_ON    = 4'd1,
    STP_BUS_ON    = 4'd2,
    STP_LINK_ON   = 4'd3,
    STP_LP_ENTER  = 4'd4,
    STP_LP_EXIT   = 4'd5,
    STP_CLAMP_ON  = 4'd6,
    STP_CLAMP_OFF = 4'd7,
    STP_LINK_OFF  = 4'd8,
    STP_BUS_OFF   = 4'd9,
    STP_REG_OFF   = 4'd10
  } step_e;

  typedef enum logic [1:0] {MD_UP, MD_DOWN, MD_UNDO} mode_e;

  localparam int IDX_W = 3;

  // mask bit per undoable step: [0] rail, [1] bus clock, [2] link clock
  function automatic logic [2:0] undo_bit(step_e s);
    logic [2:0] m;
    m = 3'b000;
    case (s)
      STP_REG_ON:  m = 3'b001;
      STP_BUS_ON:  m = 3'b010;
      STP_LINK_ON: m = 3'b100;
      default:     m = 3'b000;
    endcase
    return m;
  endfunction

  function automatic logic [IDX_W-1:0] phase_count(mode_e m);
    logic [IDX_W-1:0] n;
    case (m)
      MD_UP:   n = 3'd6;
      MD_DOWN: n = 3'd5;
      MD_UNDO: n = 3'd3;
      default: n = 3'd0;
    endcase
    return n;
  endfunction

  // down path does the full ULP + clamp treatment only under this gate
  function automatic logic down_gate(logic feat, logic pon, logic susp);
    return (feat & pon) | (susp & ~pon);
  endfunction

  // step for phase idx of mode m; STP_NONE means the phase is skipped
  function automatic step_e pick_step(mode_e m, logic [IDX_W-1:0] idx,
                                      logic bus, logic link, logic gate,
                                      logic lp, logic clamp, logic [2:0] undo);
    step_e s;
    s = STP_NONE;
    case (m)
      MD_UP: case (idx)
        3'd0: if (bus) s = STP_REG_ON;
        3'd1: if (bus) s = STP_BUS_ON;
        3'd2: if (link && clamp) s = STP_LP_ENTER;
        3'd3: if (link && clamp) s = STP_CLAMP_OFF;
        3'd4: if (link) s = STP_LINK_ON;
        3'd5: if (link && lp) s = STP_LP_EXIT;
        default: s = STP_NONE;
      endcase
      MD_DOWN: case (idx)
        3'd0: if (link && gate) s = STP_LP_ENTER;
        3'd1: if (link) s = STP_LINK_OFF;
        3'd2: if (link && gate) s = STP_CLAMP_ON;
        3'd3: if (bus) s = STP_BUS_OFF;
        3'd4: if (bus) s = STP_REG_OFF;
        default: s = STP_NONE;
      endcase
      MD_UNDO: case (idx)
        3'd0: if (undo[2]) s = STP_LINK_OFF;
        3'd1: if (undo[1]) s = STP_BUS_OFF;
        3'd2: if (undo[0]) s = STP_REG_OFF;
        default: s = STP_NONE;
      endcase
      default: s = STP_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dls_ack_timer.sv
module dls_ack_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign expired = run && !ack && (cnt == CW'(LIMIT - 1));

  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < CW'(LIMIT)));  // R9
endmodule

// File: rtl/dls_lane_flags.sv
module dls_lane_flags
  import dls_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ok_evt,
  input  step_e code,
  output logic  lp_q,
  output logic  clamp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lp_q    <= 1'b0;
      clamp_q <= 1'b0;
    end else if (ok_evt) begin
      case (code)
        STP_LP_ENTER:  lp_q    <= 1'b1;
        STP_LP_EXIT:   lp_q    <= 1'b0;
        STP_CLAMP_ON:  clamp_q <= 1'b1;
        STP_CLAMP_OFF: clamp_q <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_LP_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_q) |-> $past(ok_evt && code == STP_LP_ENTER));  // R10
  AST_CLAMP_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_q) |-> $past(ok_evt && code == STP_CLAMP_OFF));  // R10
endmodule

// File: rtl/dls_pwr_seq.sv
module dls_pwr_seq
  import dls_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_enable,
  input  logic       req_bus,
  input  logic       req_link,
  input  logic       cfg_lp_feature,
  input  logic       cfg_panel_on,
  input  logic       cfg_lp_suspend,
  output logic       step_pulse,
  output logic [3:0] step_code,
  input  logic       ack_valid,
  input  logic       ack_ok,
  output logic       busy,
  output logic       done,
  output logic [3:0] err_code,
  output logic       lp_state,
  output logic       clamp_state
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} st_e;

  st_e              st;
  mode_e            mode;
  logic [IDX_W-1:0] idx;
  logic             en_q, bus_q, link_q, gate_q;
  logic [2:0]       undo_q;
  step_e            cur_q, err_q, sel;
  logic             lp_q, clamp_q;

  // named internal events
  logic evt_accept, evt_expired, evt_resolve, evt_ok, evt_fail_up, last_phase;

  assign sel         = pick_step(mode, idx, bus_q, link_q, gate_q, lp_q, clamp_q, undo_q);
  assign last_phase  = (idx == phase_count(mode));
  assign evt_accept  = (st == ST_IDLE) && req_valid;
  assign evt_resolve = (st == ST_WAIT) && (ack_valid || evt_expired);
  assign evt_ok      = (st == ST_WAIT) && ack_valid && ack_ok;
  assign evt_fail_up = evt_resolve && !evt_ok && (mode == MD_UP);

  dls_ack_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st == ST_WAIT), .ack(ack_valid),
    .expired(evt_expired)
  );

  dls_lane_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ok_evt(evt_ok), .code(cur_q),
    .lp_q(lp_q), .clamp_q(clamp_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode   <= MD_UP;
      idx    <= '0;
      en_q   <= 1'b0;
      bus_q  <= 1'b0;
      link_q <= 1'b0;
      gate_q <= 1'b0;
      undo_q <= '0;
      cur_q  <= STP_NONE;
      err_q  <= STP_NONE;
    end else begin
      case (st)
        ST_IDLE: if (evt_accept) begin
          en_q   <= req_enable;
          bus_q  <= req_bus;
          link_q <= req_link;
          gate_q <= down_gate(cfg_lp_feature, cfg_panel_on, cfg_lp_suspend);
          mode   <= req_enable ? MD_UP : MD_DOWN;
          idx    <= '0;
          undo_q <= '0;
          err_q  <= STP_NONE;
          st     <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (last_phase)            st <= ST_DONE;
          else if (sel == STP_NONE)  idx <= idx + 1'b1;
          else begin
            cur_q <= sel;
            st    <= ST_WAIT;
          end
        end
        ST_WAIT: if (evt_resolve) begin
          st <= ST_ISSUE;
          if (evt_fail_up) begin
            err_q <= cur_q;
            mode  <= MD_UNDO;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
            if (mode == MD_UP) undo_q <= undo_q | undo_bit(cur_q);
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign step_pulse  = (st == ST_ISSUE) && (sel != STP_NONE);
  assign step_code   = step_pulse ? sel : STP_NONE;
  assign busy        = (st != ST_IDLE);
  assign done        = (st == ST_DONE);
  assign err_code    = err_q;
  assign lp_state    = lp_q;
  assign clamp_state = clamp_q;

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !step_pulse);  // R11
  AST_DOWN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !en_q) |-> (err_code == 4'd0));  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));  // R12
  AST_FAIL_ENDS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fail_up |=> (mode == MD_UNDO));  // R5
endmodule

// File: tb/dls_pwr_seq_test.sv
module dls_pwr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_enable = 0, req_bus = 0, req_link = 0;
  logic cfg_lp_feature = 0, cfg_panel_on = 0, cfg_lp_suspend = 0;
  logic ack_valid = 0, ack_ok = 0;
  logic step_pulse, busy, done, lp_state, clamp_state;
  logic [3:0] step_code, err_code;

  int checks = 0, errors = 0;
  logic [3:0] exp_q[$];
  int fail_code = 0, silent_code = 0, resp_wait = 1;
  int last_cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dls_pwr_seq #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_enable(req_enable),
    .req_bus(req_bus), .req_link(req_link), .cfg_lp_feature(cfg_lp_feature),
    .cfg_panel_on(cfg_panel_on), .cfg_lp_suspend(cfg_lp_suspend),
    .step_pulse(step_pulse), .step_code(step_code), .ack_valid(ack_valid),
    .ack_ok(ack_ok), .busy(busy), .done(done), .err_code(err_code),
    .lp_state(lp_state), .clamp_state(clamp_state)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // responder: acks each step after resp_wait falling edges
  initial begin
    int pend;
    logic [3:0] pcode;
    pend = 0; pcode = 0;
    forever begin
      @(negedge clk);
      ack_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          ack_valid = 1;
          ack_ok = (int'(pcode) != fail_code);
        end
      end
      if (step_pulse && int'(step_code) != silent_code) begin
        pend = resp_wait;
        pcode = step_code;
      end
    end
  end

  // scoreboard monitor
  initial begin
    logic prev;
    logic [3:0] e;
    prev = 0;
    forever begin
      @(negedge clk);
      if (step_pulse) begin
        chk(!prev, "R2 pulse longer than one cycle", 1, 0);
        if (exp_q.size() == 0) chk(0, "R11 unexpected step", int'(step_code), 0);
        else begin
          e = exp_q.pop_front();
          chk(step_code == e, "R2 step code order", int'(step_code), int'(e));
        end
      end
      prev = step_pulse;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic push(input int a);
    exp_q.push_back(a[3:0]);
  endtask

  task automatic run_req(input logic en, b, l, f, p, s,
                         input int exp_err, input logic exp_lp, exp_cl,
                         input string tag, input bit poke);
    bit got;
    int cyc;
    @(negedge clk);
    cfg_lp_feature = f; cfg_panel_on = p; cfg_lp_suspend = s;
    req_enable = en; req_bus = b; req_link = l; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      req_valid = 1; req_enable = ~en; req_bus = 1; req_link = 1;
    end
    got = 0; cyc = 1;
    while (!got && cyc < 3000) begin
      if (done) got = 1;
      else begin
        @(negedge clk);
        cyc++;
        req_valid = 0;
      end
    end
    last_cycles = cyc;
    chk(got, {tag, " R12 done seen"}, got, 1);
    chk(int'(err_code) == exp_err, {tag, " err_code"}, int'(err_code), exp_err);
    chk(lp_state == exp_lp, {tag, " R10 lp flag"}, lp_state, exp_lp);
    chk(clamp_state == exp_cl, {tag, " R10 clamp flag"}, clamp_state, exp_cl);
    chk(exp_q.size() == 0, {tag, " missing steps"}, exp_q.size(), 0);
    @(negedge clk);
    chk(!busy && !done, {tag, " R12 busy/done after done"}, {busy, done}, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !step_pulse, "R1 reset outputs", {busy, done, step_pulse}, 0);
    chk(err_code == 0, "R1 reset err_code", int'(err_code), 0);
    chk(!lp_state && !clamp_state, "R1 reset flags", {lp_state, clamp_state}, 0);

    // R3 R4 R8 power-up both, all ok
    push(1); push(2); push(3);
    run_req(1, 1, 1, 1, 1, 0, 0, 0, 0, "R8 up both", 0);

    // R6 R7 R8 down both, feature on, panel on
    resp_wait = 3;
    push(4); push(8); push(6); push(9); push(10);
    run_req(0, 1, 1, 1, 1, 0, 0, 1, 1, "R6 down both gated", 0);

    // R4 up both with clamps engaged
    resp_wait = 1;
    push(1); push(2); push(4); push(7); push(3); push(5);
    run_req(1, 1, 1, 1, 1, 0, 0, 0, 0, "R4 up with clamp", 0);

    // R6 down link, gate off -> only link clock off
    push(8);
    run_req(0, 0, 1, 0, 1, 0, 0, 0, 0, "R6 down plain", 0);

    // R7 rail-off failure ignored
    fail_code = 10;
    push(9); push(10);
    run_req(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7 down rail fail", 0);

    // R3 R5 bus clock on fails
    fail_code = 2;
    push(1); push(2); push(10);
    run_req(1, 1, 0, 0, 0, 0, 2, 0, 0, "R3 bus on fail", 0);

    // R6 suspend branch: panel off, ULP-in-suspend on
    fail_code = 0;
    push(4); push(8); push(6);
    run_req(0, 0, 1, 0, 0, 1, 0, 1, 1, "R6 down suspend", 0);

    // R5 ULP exit fails -> full reverse unwind
    fail_code = 5; resp_wait = 2;
    push(1); push(2); push(4); push(7); push(3); push(5); push(8); push(9); push(10);
    run_req(1, 1, 1, 1, 1, 0, 5, 1, 0, "R5 lp exit fail", 0);

    // R9 silent link clock -> timeout failure, nothing to undo
    fail_code = 0; silent_code = 3; resp_wait = 1;
    push(3);
    run_req(1, 0, 1, 1, 1, 0, 3, 1, 0, "R9 timeout", 0);
    chk(last_cycles >= TMO, "R9 timeout not early", last_cycles, TMO);

    // R4 up link with ULP active -> clock on then exit
    silent_code = 0;
    push(3); push(5);
    run_req(1, 0, 1, 1, 1, 0, 0, 0, 0, "R4 up link lp", 0);

    // R11 empty request
    run_req(1, 0, 0, 1, 1, 0, 0, 0, 0, "R11 empty", 0);

    // R11 request poked while busy is ignored
    push(8); push(9); push(10);
    run_req(0, 1, 1, 0, 1, 0, 0, 0, 0, "R11 busy poke", 1);
    repeat (30) @(negedge clk);
    chk(!busy, "R11 no extra request", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule